// File: doc/BRIEF.md
# Codec Register Access Slot Scheduler

This block prepares the outgoing words for every sample slot of a serial link to a line-interface codec. Each slot carries one 16-bit audio word and one 16-bit control command. Slots are grouped into chunks of `CHUNK_SLOTS`. Software-side register writes are queued during one chunk and sent in the slots of the next chunk. Any slot that has no write sends a polling read of a status register taken from a fixed list. The codec's replies come back one chunk later at the same slot position. They are stored in a 32-entry shadow register file, which can be read at any time through a combinational port.

The codec may return replies shifted by some slots against the commands that caused them. The block detects this when a reply carries the PLL divider value 0x89, which only register 9 returns. It then adjusts an offset so that this reply, and all later ones, land on the correct register.

A small phase state machine follows the chunk. `PH_OPEN` is the first slot of the chunk. `PH_BODY` covers the middle slots. `PH_CLOSE` is the last slot. Each `slot_go` pulse moves `PH_OPEN` to `PH_BODY`, or to `PH_CLOSE` when the next slot is the last one. `PH_BODY` stays in `PH_BODY` until the next slot is the last, then moves to `PH_CLOSE`. `PH_CLOSE` returns to `PH_OPEN`. The pulse in `PH_CLOSE` is the chunk end: at that point the write queue is handed over and the poll pointer may be rewound.

Top module: `codec_slot_sched`

## Requirements
- R1: For every slot, the output audio word equals `tx_sample` with bit 0 forced to 1.
- R2: While `invert_en` is high during a slot, both the audio word and the command word issued for that slot are bitwise complemented.
- R3: A polling read of register r is encoded as the command `{(r | 8'h20), 8'h00}`.
- R4: A write of value v to register r is encoded as the command `{r, v}`.
- R5: The write queue holds at most `CHUNK_SLOTS` requests. Each request is answered in its own cycle: `wr_accept` when there is room, otherwise `wr_reject`. A request made in the chunk-end cycle enters an emptied queue and is accepted.
- R6: Writes accepted before a chunk end are sent in the following chunk, in arrival order, starting at slot 0. A write is never sent in the chunk during which it was queued.
- R7: A slot without a queued write polls the next register of the list 5, 6, 9, 11, 12, 13, 17, 19. The poll pointer wraps from the eighth entry back to the first.
- R8: If any write was sent in a chunk, the poll pointer returns to the first list entry at that chunk's end.
- R9: The low byte of the reply, received in slot k, belongs to the command sent in slot k of the previous chunk. If that command was a read, the byte is stored in the shadow entry of the expected register. The expected register is the list entry at (poll index + offset) mod 8. Replies to writes are not stored.
- R10: For the 4 slots that follow a slot carrying a write, replies are not stored.
- R11: A reply of 0x89 whose expected register is not 9 moves the offset so that the expected register becomes 9. The byte is stored in entry 9, and the new offset applies to all later replies.
- R12: After reset, every shadow entry reads 0, the output words are 0 and `tx_valid` is low.
- R13: `tx_valid`, `tx_audio` and `tx_cmd` are registered and update in the cycle after `slot_go`. The words hold their value between slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| invert_en | input | 1 | Complement the outgoing audio and command words |
| slot_go | input | 1 | One pulse per sample slot |
| tx_sample | input | 16 | Audio sample for the current slot |
| rx_reply | input | 8 | Low byte of the received control word for the current slot |
| wr_req | input | 1 | Register write request |
| wr_reg | input | 8 | Register number for the write request |
| wr_val | input | 8 | Value for the write request |
| wr_accept | output | 1 | Request queued (same cycle) |
| wr_reject | output | 1 | Request refused because the queue is full (same cycle) |
| tx_valid | output | 1 | Pulse: new slot words are present |
| tx_audio | output | 16 | Outgoing audio word |
| tx_cmd | output | 16 | Outgoing control command word |
| shadow_addr | input | 5 | Shadow register read address |
| shadow_data | output | 8 | Shadow register contents at `shadow_addr` |

## Verification
The bench uses the default parameters: `CHUNK_SLOTS` of 8, a 4-slot capture quiet window and a 32-entry shadow file. With these values, a single chunk walks the whole poll list once, so the wrap and the rewind after a write chunk both show up within a few chunks. The bench sends ten requests during one chunk, so the two refused ones are visible. Because the quiet window is shorter than a chunk, a chunk with only two writes shows both suppressed and captured replies in the slots after them. The bench also injects a 0x89 reply at a slot that expects register 17 and applies inversion for two chunks.

// File: rtl/codec_slot_pkg.sv
package codec_slot_pkg;

    localparam int POLL_LEN = 8;
    localparam int POLL_IW  = 3;

    localparam logic [7:0]         SIGNATURE = 8'h89;
    localparam logic [4:0]         SIG_REG   = 5'd9;
    localparam logic [POLL_IW-1:0] SIG_POS   = 3'd2;
    localparam logic [7:0]         READ_FLAG = 8'h20;

    typedef enum logic [1:0] {
        PH_OPEN  = 2'd0,
        PH_BODY  = 2'd1,
        PH_CLOSE = 2'd2
    } phase_e;

    typedef struct packed {
        logic       is_write;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_entry_t;

    typedef struct packed {
        logic               is_read;
        logic [POLL_IW-1:0] pidx;
    } slot_rec_t;

    function automatic logic [4:0] poll_reg(input logic [POLL_IW-1:0] i);
        logic [4:0] r;
        case (i)
            3'd0:    r = 5'd5;
            3'd1:    r = 5'd6;
            3'd2:    r = 5'd9;
            3'd3:    r = 5'd11;
            3'd4:    r = 5'd12;
            3'd5:    r = 5'd13;
            3'd6:    r = 5'd17;
            default: r = 5'd19;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cs_write_queue.sv
module cs_write_queue
    import codec_slot_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic [7:0]      wr_reg,
    input  logic [7:0]      wr_val,
    input  logic            chunk_end,
    input  logic [IW-1:0]   slot_idx,
    output logic            wr_accept,
    output logic            wr_reject,
    output wr_entry_t       slot_entry
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0] pend_cnt;
    wr_entry_t     pend_q [DEPTH];
    wr_entry_t     act_q  [DEPTH];
    wr_entry_t     req_e;
    logic          room;

    always_comb begin
        req_e.is_write = 1'b1;
        req_e.addr     = wr_reg;
        req_e.data     = wr_val;
        room           = chunk_end || (pend_cnt < CW'(DEPTH));
        wr_accept      = wr_req && room;
        wr_reject      = wr_req && !room;
        slot_entry     = act_q[slot_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_cnt <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                pend_q[i] <= '0;
                act_q[i]  <= '0;
            end
        end else if (chunk_end) begin
            for (int i = 0; i < DEPTH; i++) begin
                act_q[i] <= (CW'(i) < pend_cnt) ? pend_q[i] : '0;
            end
            if (wr_req) begin
                pend_q[0] <= req_e;
                pend_cnt  <= CW'(1);
            end else begin
                pend_cnt  <= '0;
            end
        end else if (wr_accept) begin
            pend_q[pend_cnt[IW-1:0]] <= req_e;
            pend_cnt                 <= pend_cnt + 1'b1;
        end
    end

    // R5: queue occupancy never exceeds one chunk of slots
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= CW'(DEPTH));

    // R5: an accepted request outside a chunk end grows the queue by one
    p_accept_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && !chunk_end) |=> (pend_cnt == $past(pend_cnt) + 1'b1));

endmodule

// File: rtl/cs_reply_map.sv
module cs_reply_map
    import codec_slot_pkg::*;
#(
    parameter int SHADOW_DEPTH = 32,
    parameter int IGN_SLOTS    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_go,
    input  slot_rec_t     rec,
    input  logic [7:0]    rx_byte,
    input  logic          issue_write,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int AW = $clog2(SHADOW_DEPTH);
    localparam int GW = $clog2(IGN_SLOTS + 1);

    logic [7:0]         shadow [SHADOW_DEPTH];
    logic [POLL_IW-1:0] offset;
    logic [GW-1:0]      ign;
    logic [POLL_IW-1:0] exp_pos;
    logic [4:0]         exp_reg;
    logic [4:0]         store_reg;
    logic               sig_hit;
    logic               capture;

    always_comb begin
        exp_pos   = rec.pidx + offset;
        exp_reg   = poll_reg(exp_pos);
        sig_hit   = (rx_byte == SIGNATURE) && (exp_reg != SIG_REG);
        capture   = slot_go && rec.is_read && (ign == '0);
        store_reg = sig_hit ? SIG_REG : exp_reg;
        rd_data   = shadow[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset <= '0;
            ign    <= '0;
            for (int i = 0; i < SHADOW_DEPTH; i++) shadow[i] <= '0;
        end else begin
            if (capture) begin
                shadow[AW'(store_reg)] <= rx_byte;
                if (sig_hit) offset <= SIG_POS - rec.pidx;
            end
            if (slot_go) begin
                if (issue_write)   ign <= GW'(IGN_SLOTS);
                else if (ign != 0) ign <= ign - 1'b1;
            end
        end
    end

    // R10: a slot carrying a write opens the full quiet window
    p_quiet_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_go && issue_write) |=> (ign == GW'(IGN_SLOTS)));

    // R11: the offset only moves on a signature reply
    p_offset_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_go && rx_byte == SIGNATURE) |=> $stable(offset));

    // R11: after a resync, the same slot now maps onto register 9
    p_resync_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && sig_hit) |=> (poll_reg(POLL_IW'(offset + $past(rec.pidx))) == SIG_REG));

endmodule

// File: rtl/codec_slot_sched.sv
module codec_slot_sched
    import codec_slot_pkg::*;
#(
    parameter int CHUNK_SLOTS  = 8,
    parameter int SHADOW_DEPTH = 32,
    parameter int IGN_SLOTS    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        invert_en,
    input  logic        slot_go,
    input  logic [15:0] tx_sample,
    input  logic [7:0]  rx_reply,
    input  logic        wr_req,
    input  logic [7:0]  wr_reg,
    input  logic [7:0]  wr_val,
    output logic        wr_accept,
    output logic        wr_reject,
    output logic        tx_valid,
    output logic [15:0] tx_audio,
    output logic [15:0] tx_cmd,
    input  logic [4:0]  shadow_addr,
    output logic [7:0]  shadow_data
);
    localparam int SW = (CHUNK_SLOTS > 1) ? $clog2(CHUNK_SLOTS) : 1;
    localparam logic [SW-1:0] LAST_SLOT = SW'(CHUNK_SLOTS - 1);

    phase_e             phase_q, phase_d;
    logic [SW-1:0]      slot_q, slot_d;
    logic               chunk_end;
    wr_entry_t          cur;
    logic               issue_write;
    logic [POLL_IW-1:0] poll_ptr;
    logic               wrote_q;
    slot_rec_t          rec_q [CHUNK_SLOTS];
    slot_rec_t          new_rec;
    logic [15:0]        cmd_word;
    logic [15:0]        audio_word;
    logic [15:0]        inv_mask;

    // next-state logic of the chunk phase machine
    always_comb begin
        phase_d = phase_q;
        slot_d  = slot_q;
        if (slot_go) begin
            unique case (phase_q)
                PH_OPEN, PH_BODY: begin
                    slot_d  = slot_q + 1'b1;
                    phase_d = (slot_d == LAST_SLOT) ? PH_CLOSE : PH_BODY;
                end
                PH_CLOSE: begin
                    slot_d  = '0;
                    phase_d = PH_OPEN;
                end
                default: begin
                    slot_d  = '0;
                    phase_d = PH_OPEN;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_OPEN;
            slot_q  <= '0;
        end else begin
            phase_q <= phase_d;
            slot_q  <= slot_d;
        end
    end

    assign chunk_end = slot_go && (phase_q == PH_CLOSE);

    cs_write_queue #(.DEPTH(CHUNK_SLOTS)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req),
        .wr_reg     (wr_reg),
        .wr_val     (wr_val),
        .chunk_end  (chunk_end),
        .slot_idx   (slot_q),
        .wr_accept  (wr_accept),
        .wr_reject  (wr_reject),
        .slot_entry (cur)
    );

    cs_reply_map #(.SHADOW_DEPTH(SHADOW_DEPTH), .IGN_SLOTS(IGN_SLOTS)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_go     (slot_go),
        .rec         (rec_q[slot_q]),
        .rx_byte     (rx_reply),
        .issue_write (issue_write),
        .rd_addr     (shadow_addr),
        .rd_data     (shadow_data)
    );

    // frame word build
    always_comb begin
        issue_write     = cur.is_write;
        audio_word      = tx_sample | 16'h0001;
        inv_mask        = {16{invert_en}};
        if (issue_write) cmd_word = {cur.addr, cur.data};
        else             cmd_word = {({3'b000, poll_reg(poll_ptr)} | READ_FLAG), 8'h00};
        new_rec.is_read = !issue_write;
        new_rec.pidx    = poll_ptr;
    end

    // output and per-slot bookkeeping process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_audio <= '0;
            tx_cmd   <= '0;
            poll_ptr <= '0;
            wrote_q  <= 1'b0;
            for (int i = 0; i < CHUNK_SLOTS; i++) rec_q[i] <= '0;
        end else begin
            tx_valid <= slot_go;
            if (slot_go) begin
                tx_audio      <= audio_word ^ inv_mask;
                tx_cmd        <= cmd_word ^ inv_mask;
                rec_q[slot_q] <= new_rec;
                if (phase_q == PH_CLOSE) begin
                    wrote_q <= 1'b0;
                    if (wrote_q || issue_write) poll_ptr <= '0;
                    else                        poll_ptr <= poll_ptr + 1'b1;
                end else begin
                    wrote_q <= wrote_q | issue_write;
                    if (!issue_write) poll_ptr <= poll_ptr + 1'b1;
                end
            end
        end
    end

    // R1: the audio LSB is always the marker bit (after optional inversion)
    p_audio_lsb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_audio[0] == !$past(invert_en)));

    // R8: a chunk that sent a write restarts polling at the list head
    p_ptr_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_end && (wrote_q || issue_write)) |=> (poll_ptr == '0));

    // R13: output pulse follows the slot strobe by one cycle
    p_valid_follows_r13: assert property (@(posedge clk) disable iff (!rst_n)
        slot_go |=> tx_valid);

endmodule

// File: tb/codec_slot_sched_test.sv
module codec_slot_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int CH         = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        invert_en = 1'b0;
    logic        slot_go = 1'b0;
    logic [15:0] tx_sample = '0;
    logic [7:0]  rx_reply = '0;
    logic        wr_req = 1'b0;
    logic [7:0]  wr_reg = '0;
    logic [7:0]  wr_val = '0;
    logic        wr_accept, wr_reject, tx_valid;
    logic [15:0] tx_audio, tx_cmd;
    logic [4:0]  shadow_addr = '0;
    logic [7:0]  shadow_data;

    codec_slot_sched #(.CHUNK_SLOTS(CH)) uut (
        .clk(clk), .rst_n(rst_n), .invert_en(invert_en), .slot_go(slot_go),
        .tx_sample(tx_sample), .rx_reply(rx_reply), .wr_req(wr_req),
        .wr_reg(wr_reg), .wr_val(wr_val), .wr_accept(wr_accept),
        .wr_reject(wr_reject), .tx_valid(tx_valid), .tx_audio(tx_audio),
        .tx_cmd(tx_cmd), .shadow_addr(shadow_addr), .shadow_data(shadow_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // reference model state
    int          m_slot = 0, m_ptr = 0, m_off = 0, m_ign = 0;
    bit          m_wrote = 0;
    bit          m_prev_rd [CH];
    int          m_prev_px [CH];
    logic [7:0]  m_shadow [32];
    logic [15:0] m_pend [$];
    logic [15:0] m_act [$];
    logic        e_valid = 0;
    logic [15:0] e_audio = '0, e_cmd = '0;
    string       e_tag = "R12";
    int          wk = 0;

    function automatic int plist(input int i);
        case (i)
            0: return 5;   1: return 6;   2: return 9;   3: return 11;
            4: return 12;  5: return 13;  6: return 17;  default: return 19;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    task automatic model_step(input bit go, input logic [15:0] smp, input logic [7:0] rx, input bit inv);
        int er;
        bit is_w;
        logic [15:0] cmd;
        e_valid = go;
        if (!go) return;
        // reply side: R9, R10, R11
        if (m_prev_rd[m_slot] && m_ign == 0) begin
            er = plist((m_prev_px[m_slot] + m_off) % 8);
            if (rx == 8'h89 && er != 9) begin
                while (plist((m_prev_px[m_slot] + m_off) % 8) != 9) m_off = (m_off + 1) % 8;
                er = 9;
            end
            m_shadow[er] = rx;
        end
        // transmit side: R3, R4, R6, R7
        is_w = (m_slot < m_act.size());
        if (is_w) begin
            cmd = m_act[m_slot];
            e_tag = "R4 R6";
        end else begin
            cmd = {8'(plist(m_ptr)) | 8'h20, 8'h00};
            m_prev_px[m_slot] = m_ptr;
            m_ptr = (m_ptr + 1) % 8;
            e_tag = "R3 R7 R8";
        end
        m_prev_rd[m_slot] = !is_w;
        if (is_w) m_ign = 4;
        else if (m_ign > 0) m_ign--;
        if (is_w) m_wrote = 1;
        e_audio = (smp | 16'h0001) ^ {16{inv}};
        e_cmd   = cmd ^ {16{inv}};
        if (m_slot == CH - 1) begin
            if (m_wrote) m_ptr = 0;
            m_wrote = 0;
            m_act = m_pend;
            m_pend.delete();
            m_slot = 0;
        end else begin
            m_slot++;
        end
    endtask

    task automatic tick(input bit go, input logic [15:0] smp, input logic [7:0] rx,
                        input bit req, input logic [7:0] ra, input logic [7:0] rv, input bit inv);
        bit ce, acc;
        slot_go = go; tx_sample = smp; rx_reply = rx;
        wr_req = req; wr_reg = ra; wr_val = rv; invert_en = inv;
        #1;
        ce  = go && (m_slot == CH - 1);
        acc = req && (ce || m_pend.size() < CH);
        check("R5 accept", {15'b0, wr_accept}, {15'b0, acc});
        check("R5 reject", {15'b0, wr_reject}, {15'b0, req && !acc});
        check("R9 R10 R11 shadow", {8'b0, shadow_data}, {8'b0, m_shadow[shadow_addr]});
        @(posedge clk);
        model_step(go, smp, rx, inv);
        if (acc) m_pend.push_back({ra, rv});
        @(negedge clk);
        check("R13 valid", {15'b0, tx_valid}, {15'b0, e_valid});
        check("R1 R2 audio", tx_audio, e_audio);
        check(e_tag, tx_cmd, e_cmd);
        shadow_addr = shadow_addr + 5'd1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) m_shadow[i] = '0;
        for (int i = 0; i < CH; i++) begin m_prev_rd[i] = 0; m_prev_px[i] = 0; end
        // R12: reset state
        repeat (3) @(negedge clk);
        for (int a = 0; a < 32; a++) begin
            shadow_addr = 5'(a);
            #1;
            check("R12 shadow reset", {8'b0, shadow_data}, 16'h0000);
        end
        check("R12 valid reset", {15'b0, tx_valid}, 16'h0000);
        check("R12 audio reset", tx_audio, 16'h0000);
        check("R12 cmd reset", tx_cmd, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        shadow_addr = '0;

        for (int c = 0; c < 12; c++) begin
            for (int s = 0; s < CH; s++) begin
                logic [7:0] rx;
                logic [15:0] smp;
                bit inv;
                bit req_end;
                rx  = 8'((c * 8 + s) * 37 + 11);
                if (rx == 8'h89) rx = 8'h88;
                if (c == 6 && s == 6) rx = 8'h89;          // R11 signature injection
                smp = 16'((c * 1021 + s * 97) * 131);
                inv = (c == 9 || c == 10);                  // R2
                req_end = (c == 8 && s == CH - 1);          // R5 request at chunk end
                tick(1'b1, smp, rx, req_end, 8'h30, 8'h5A, inv);
                for (int g = 0; g < 2; g++) begin
                    bit rq;
                    rq = (c == 2 && s < 5) || (c == 5 && s < 2 && g == 0);
                    tick(1'b0, 16'hFFFF, 8'h00, rq, 8'(8'h10 + wk), 8'(8'hA0 + wk), inv);
                    if (rq) wk++;
                end
            end
        end
        repeat (4) tick(1'b0, 16'h0, 8'h0, 1'b0, 8'h0, 8'h0, 1'b0);
        finish_run();
    end
endmodule